// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of a 12-bit successive-approximation converter. A 16-bit control register holds the run enable, the input mode and two timing codes, one for the ADC clock divider and one for the acquisition length. A start pulse launches one conversion. The system clock is divided down to ADC clock ticks. The block holds the track-and-hold in acquisition for a set number of ticks, then spends 19 more ticks on 12 bit trials and a settle/write tail. At the end it stores a 32-bit result word and raises a ready flag and an interrupt in the same cycle.

The analog comparator sits outside the block. Each trial code is presented on `dac_code`, and the comparator answers on `cmp_in`. When the channel select points at the temperature sensor, the timing of that one conversion is fixed by the block and the register codes are bypassed. The next conversion on any other channel takes its timing from the register again. The number format of the stored word follows the input mode latched at start.

The sequencer is one state machine with four states:
- `ST_IDLE` leads to `ST_ACQ` on an accepted start.
- `ST_ACQ` leads to `ST_TRIAL` on the last acquisition tick.
- `ST_TRIAL` leads to `ST_WRITE` on the twelfth trial tick.
- `ST_WRITE` leads back to `ST_IDLE` on the last settle tick, which is the edge where the result word is written.

Top module: `sar_seq_top`

## Requirements
- R1: After reset the control register reads 0x0600, `busy`, `status` and `irq` are 0, and `data_out` is 0.
- R2: The control register fields are as follows, and every other bit reads as 0:
  - bit 0 is the enable.
  - bits 2:1 are the mode: 0 single-ended, 1 pseudo-differential, 2 or 3 fully differential.
  - bits 7:5 hold the divider code d, giving a divider of 2<<d system clocks.
  - bits 10:9 hold the acquisition code a, giving 1<<a ADC clocks.
- R3: For a non-temperature channel, `status` rises exactly div*(acq+19) system clock edges after the edge that accepts the start, with div and acq taken from the register.
- R4: When `chan_sel` is 15 (the temperature sensor), the conversion uses 16 acquisition clocks and a divider of 32 (1120 edges), whatever the register holds. A following conversion on another channel uses the register timing again.
- R5: `busy` is 1 from the accepting edge until completion, and `status` is 0 during that time. At completion `busy` falls while `status` and `irq` rise on the same edge. `sample` is 1 only during acquisition.
- R6: The 12-bit result is found MSB first, one bit per ADC clock: a trial bit is kept when `cmp_in` is 1 for the code on `dac_code`. The result therefore equals the comparator's threshold code.
- R7: The result field sits in bits 27:16 of `data_out`, and bits 15:0 are 0. In single-ended and pseudo-differential modes the field is the raw SAR code and bits 31:28 are 0.
- R8: In fully differential mode the field is the SAR code with its MSB inverted (two's complement), and bits 31:28 copy bit 27.
- R9: A start while `busy` is ignored: the completion time and the result are those of the running conversion.
- R10: A start while the enable bit is 0 starts nothing and leaves `status` and `data_out` unchanged.
- R11: A `data_rd` pulse clears `status` and `irq` on the next edge, and `data_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register contents |
| chan_sel | input | 4 | Channel select; 15 is the temperature sensor |
| start | input | 1 | Conversion start request |
| cmp_in | input | 1 | Comparator answer: input at or above `dac_code` |
| dac_code | output | 12 | Trial code for the capacitor DAC |
| sample | output | 1 | Track-and-hold acquire enable |
| busy | output | 1 | Conversion in progress |
| status | output | 1 | Result ready flag |
| irq | output | 1 | End-of-conversion interrupt |
| data_rd | input | 1 | Data register read strobe |
| data_out | output | 32 | Formatted result word |

## Verification
A state machine that leaves a phase one tick early or late moves the rise of `status` by a whole multiple of the divider, so it shows within a single conversion as a wrong completion count. A trial bit that is kept or dropped wrongly, or a wrong format step, shows in `data_out` on the completion edge. A start that is wrongly accepted while busy restarts the count and delays completion. A temperature override that is latched too long shows as a 1120-edge count on the next ordinary conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_TRIAL = 2'd2,
        ST_WRITE = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_PSEUDO = 2'd1,
        MODE_DIFF   = 2'd2,
        MODE_DIFF2  = 2'd3
    } in_mode_t;

    localparam int CTRL_W       = 16;
    localparam logic [15:0] CTRL_RESET = 16'h0600;
    localparam logic [15:0] CTRL_MASK  = 16'h06E7;
    localparam int EN_BIT       = 0;
    localparam int MODE_LSB     = 1;
    localparam int DIV_LSB      = 5;
    localparam int DIV_CODE_W   = 3;
    localparam int ACQ_LSB      = 9;
    localparam int ACQ_CODE_W   = 2;

endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] div_val,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div_val - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             cmp_in,
    output logic [RES_W-1:0] code
);

    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] mask_q;

    assign code = res_q | mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            mask_q <= '0;
        end else if (load) begin
            res_q  <= '0;
            mask_q <= {1'b1, {(RES_W-1){1'b0}}};
        end else if (step) begin
            if (cmp_in) begin
                res_q <= res_q | mask_q;
            end
            mask_q <= mask_q >> 1;
        end
    end

endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt
    import sar_seq_pkg::*;
#(
    parameter int RES_W   = 12,
    parameter int RES_LSB = 16,
    parameter int DATA_W  = 32
) (
    input  in_mode_t          mode,
    input  logic [RES_W-1:0]  code,
    output logic [DATA_W-1:0] word
);

    localparam int SIGN_W = DATA_W - RES_LSB - RES_W;

    logic             twos;
    logic [RES_W-1:0] field;
    logic [SIGN_W-1:0] sign;

    always_comb begin
        twos  = (mode == MODE_DIFF) || (mode == MODE_DIFF2);
        field = code;
        if (twos) begin
            field[RES_W-1] = ~code[RES_W-1];
        end
        sign = twos ? {SIGN_W{field[RES_W-1]}} : '0;
        word = {sign, field, {RES_LSB{1'b0}}};
    end

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int RES_LSB    = 16,
    parameter int DATA_W     = 32,
    parameter int CH_W       = 4,
    parameter int TEMP_CH    = 15,
    parameter int EXTRA_CLKS = 19,
    parameter int TEMP_ACQ   = 16,
    parameter int TEMP_DIV   = 32,
    parameter int CNT_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic [CH_W-1:0]   chan_sel,
    input  logic              start,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  dac_code,
    output logic              sample,
    output logic              busy,
    output logic              status,
    output logic              irq,
    input  logic              data_rd,
    output logic [DATA_W-1:0] data_out
);

    localparam int WRITE_CLKS = EXTRA_CLKS - RES_W;
    localparam int PH_W       = $clog2(TEMP_ACQ + EXTRA_CLKS + 1);

    seq_state_t state_q, state_d;

    logic [15:0]        ctrl_q;
    logic [CNT_W-1:0]   div_q, div_sel;
    logic [PH_W-1:0]    acq_q, acq_sel, ph_cnt_q;
    in_mode_t           mode_q;
    logic               is_temp, go, tick;
    logic               acq_last, trial_last, write_last, phase_end;
    logic               sar_load, sar_step, run;
    logic               status_q, irq_q;
    logic [DATA_W-1:0]  data_q, fmt_word;
    logic [DIV_CODE_W-1:0] div_code;
    logic [ACQ_CODE_W-1:0] acq_code;

    // Control register and per-conversion timing selection
    assign cfg_rdata = ctrl_q;
    assign div_code  = ctrl_q[DIV_LSB +: DIV_CODE_W];
    assign acq_code  = ctrl_q[ACQ_LSB +: ACQ_CODE_W];
    assign is_temp   = (chan_sel == CH_W'(TEMP_CH));
    assign div_sel   = is_temp ? CNT_W'(TEMP_DIV) : (CNT_W'(2) << div_code);
    assign acq_sel   = is_temp ? PH_W'(TEMP_ACQ)  : (PH_W'(1) << acq_code);
    assign go        = start && ctrl_q[EN_BIT] && (state_q == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (cfg_wr) begin
            ctrl_q <= cfg_wdata & CTRL_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= CNT_W'(2);
            acq_q  <= PH_W'(8);
            mode_q <= MODE_SINGLE;
        end else if (go) begin
            div_q  <= div_sel;
            acq_q  <= acq_sel;
            mode_q <= in_mode_t'(ctrl_q[MODE_LSB +: 2]);
        end
    end

    // ADC clock and phase counting
    sar_clkdiv #(.CNT_W(CNT_W)) u_clkdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_val (div_q),
        .tick    (tick)
    );

    assign acq_last   = tick && (state_q == ST_ACQ)   && (ph_cnt_q == acq_q - PH_W'(1));
    assign trial_last = tick && (state_q == ST_TRIAL) && (ph_cnt_q == PH_W'(RES_W - 1));
    assign write_last = tick && (state_q == ST_WRITE) && (ph_cnt_q == PH_W'(WRITE_CLKS - 1));
    assign phase_end  = acq_last || trial_last || write_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt_q <= '0;
        end else if (go || (tick && phase_end)) begin
            ph_cnt_q <= '0;
        end else if (tick) begin
            ph_cnt_q <= ph_cnt_q + PH_W'(1);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        run      = 1'b1;
        sample   = 1'b0;
        sar_load = 1'b0;
        sar_step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                run = 1'b0;
                if (go) state_d = ST_ACQ;
            end
            ST_ACQ: begin
                sample = 1'b1;
                if (acq_last) begin
                    sar_load = 1'b1;
                    state_d  = ST_TRIAL;
                end
            end
            ST_TRIAL: begin
                sar_step = tick;
                if (trial_last) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (write_last) state_d = ST_IDLE;
            end
        endcase
        busy = (state_q != ST_IDLE);
    end

    // Successive approximation and result formatting
    sar_approx_reg #(.RES_W(RES_W)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sar_load),
        .step   (sar_step),
        .cmp_in (cmp_in),
        .code   (dac_code)
    );

    sar_result_fmt #(.RES_W(RES_W), .RES_LSB(RES_LSB), .DATA_W(DATA_W)) u_fmt (
        .mode (mode_q),
        .code (dac_code),
        .word (fmt_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            status_q <= 1'b0;
            irq_q    <= 1'b0;
        end else if (write_last) begin
            data_q   <= fmt_word;
            status_q <= 1'b1;
            irq_q    <= 1'b1;
        end else if (go || data_rd) begin
            status_q <= 1'b0;
            irq_q    <= 1'b0;
        end
    end

    assign status   = status_q;
    assign irq      = irq_q;
    assign data_out = data_q;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              data_rd,
    input logic [15:0]       cfg_rdata,
    input logic              busy,
    input logic              sample,
    input logic              status,
    input logic              irq,
    input logic [DATA_W-1:0] data_out
);

    assert_busy_ready_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && status));

    assert_irq_with_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> irq);

    assert_sample_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> busy);

    assert_start_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || status));

    assert_data_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(data_out)));

    assert_disabled_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cfg_rdata[0] && !busy && !data_rd) |=>
            (!busy && $stable(data_out) && $stable(status)));

    assert_sign_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_out[31:28] == 4'h0) || (data_out[31:28] == {4{data_out[27]}}));

    assert_low_half_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_out[15:0] == 16'h0);

    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !busy) |=> (!status && !irq && $stable(data_out)));

endmodule

bind sar_seq_top sar_seq_chk #(.DATA_W(DATA_W)) u_sar_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .data_rd   (data_rd),
    .cfg_rdata (cfg_rdata),
    .busy      (busy),
    .sample    (sample),
    .status    (status),
    .irq       (irq),
    .data_out  (data_out)
);

// File: tb/test_sar_seq_top.sv
module test_sar_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [3:0]  chan_sel = '0;
    logic        start = 1'b0;
    logic        cmp_in;
    logic [11:0] dac_code;
    logic        sample, busy, status, irq;
    logic        data_rd = 1'b0;
    logic [31:0] data_out;
    logic [11:0] vin = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    // comparator stub: input at or above the trial code
    assign cmp_in = (vin >= dac_code);

    sar_seq_top i_sar_seq_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .chan_sel  (chan_sel),
        .start     (start),
        .cmp_in    (cmp_in),
        .dac_code  (dac_code),
        .sample    (sample),
        .busy      (busy),
        .status    (status),
        .irq       (irq),
        .data_rd   (data_rd),
        .data_out  (data_out)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int conv_len(input logic [15:0] ctrl, input logic temp);
        int d, a;
        d = temp ? 32 : (2 << ctrl[7:5]);
        a = temp ? 16 : (1 << ctrl[10:9]);
        return d * (a + 19);
    endfunction

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic read_data();
        @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    // one conversion; poke = extra start while busy
    task automatic convert(input logic [3:0] ch, input logic [11:0] v, input int exp_n,
                           input logic [31:0] exp_d, input string req, input logic poke);
        int n = 0;
        logic busy_ok = 1'b1;
        @(negedge clk);
        chan_sel = ch; vin = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!status && n < 5000) begin
            if (busy !== 1'b1 || status !== 1'b0) busy_ok = 1'b0;
            start = (poke && n == 10);
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        check(n == exp_n, {req, " completion edges"}, n, exp_n);
        check(busy_ok, "R5 busy high, ready low while converting", 32'(busy_ok), 1);
        check(irq && !busy, "R5 irq with ready, busy low", {busy, irq}, 32'h1);
        check(data_out == exp_d, {req, " data word"}, data_out, exp_d);
    endtask

    task automatic t_reset();
        check(cfg_rdata == 16'h0600, "R1 ctrl reset", cfg_rdata, 16'h0600);
        check({busy, status, irq} == 3'b000, "R1 flags reset", {busy, status, irq}, 0);
        check(data_out == 32'h0, "R1 data reset", data_out, 0);
    endtask

    task automatic t_reg_mask();
        write_cfg(16'hFFFF);
        check(cfg_rdata == 16'h06E7, "R2 writable bits", cfg_rdata, 16'h06E7);
    endtask

    task automatic t_single_default();
        write_cfg(16'h0601);
        convert(4'd0, 12'hA5C, 54, 32'h0A5C_0000, "R3 R6 R7 default single", 1'b0);
        read_data();
        convert(4'd1, 12'h000, 54, 32'h0000_0000, "R6 R7 zero input", 1'b0);
    endtask

    task automatic t_read_clear();
        logic [31:0] keep = data_out;
        read_data();
        check(!status && !irq, "R11 read clears flags", {status, irq}, 0);
        check(data_out == keep, "R11 data kept after read", data_out, keep);
    endtask

    task automatic t_pseudo();
        write_cfg(16'h0603);
        convert(4'd2, 12'hFFF, 54, 32'h0FFF_0000, "R7 pseudo full scale", 1'b0);
        read_data();
    endtask

    task automatic t_diff();
        write_cfg(16'h0605);
        convert(4'd2, 12'h123, 54, 32'hF923_0000, "R8 diff negative", 1'b0);
        read_data();
        convert(4'd2, 12'hC00, 54, 32'h0400_0000, "R8 diff positive", 1'b0);
        read_data();
        convert(4'd2, 12'h800, 54, 32'h0000_0000, "R8 diff zero", 1'b0);
        read_data();
    endtask

    task automatic t_user_timing_temp();
        logic [15:0] c = 16'h0241;
        write_cfg(c);
        convert(4'd3, 12'h3C1, conv_len(c, 1'b0), 32'h03C1_0000, "R3 user timing", 1'b0);
        read_data();
        convert(4'd15, 12'h7E0, conv_len(c, 1'b1), 32'h07E0_0000, "R4 temp forced", 1'b0);
        read_data();
        convert(4'd3, 12'h055, conv_len(c, 1'b0), 32'h0055_0000, "R4 user timing back", 1'b0);
        read_data();
    endtask

    task automatic t_start_busy();
        write_cfg(16'h0601);
        convert(4'd4, 12'h9AB, 54, 32'h09AB_0000, "R9 start while busy", 1'b1);
        read_data();
    endtask

    task automatic t_disabled();
        logic [31:0] keep;
        logic        saw_busy = 1'b0;
        write_cfg(16'h0601);
        convert(4'd5, 12'h321, 54, 32'h0321_0000, "R10 setup", 1'b0);
        keep = data_out;
        write_cfg(16'h0600);
        @(negedge clk);
        vin = 12'hFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 80; i++) begin
            if (busy) saw_busy = 1'b1;
            @(negedge clk);
        end
        check(!saw_busy, "R10 no conversion when disabled", 32'(saw_busy), 0);
        check(status == 1'b1, "R10 ready unchanged", status, 1);
        check(data_out == keep, "R10 data unchanged", data_out, keep);
        read_data();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reg_mask();
        t_single_default();
        t_read_clear();
        t_pseudo();
        t_diff();
        t_user_timing_temp();
        t_start_busy();
        t_disabled();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule